// File: doc/BRIEF.md
# Programmable ETU Timing Generator

This block produces the elementary-time-unit (ETU) strobe that paces a smart card UART. It runs entirely in the system clock domain. A clock-source stage first makes a base enable: either every system clock cycle, or one cycle out of every power of two picked by a 3-bit field. A prescaler divides that base enable by 31 or by 32. An 8-bit programmable divider then counts prescaler strobes and emits one ETU strobe each time it completes a full count.

Software writes the divider code through a simple write-enable and data port. The code can change while the block is running. The divider only picks up the new code when its current count ends, so the ETU that is in progress always keeps its full length. Codes 00h and 01h both mean divide-by-one. The largest ratio is 255.

Top module: `etu_timer`

## Requirements
- R1: After reset, `etu_tick` is low and the divider code register holds 00h. The block then runs at divide-by-one, so with `clk_sel`=0 and `psc_sel`=0 the ETU strobes are 31 cycles apart.
- R2: For a divider code N from 2 to 255, consecutive ETU strobes are N prescaler periods apart.
- R3: Divider codes 0 and 1 both give one ETU strobe per prescaler period.
- R4: Code 255 gives the largest spacing, 255 prescaler periods. No setting gives a ratio of 256.
- R5: `psc_sel`=0 sets the prescaler to divide by 31 and `psc_sel`=1 sets it to divide by 32.
- R6: With `clk_sel`=0 the base enable is active on every system clock cycle. With `clk_sel`=1 it is active once every 2^`src_sel` cycles.
- R7: `etu_tick` is high for exactly one system clock cycle per ETU.
- R8: A divider code written in the middle of an ETU does not change that ETU. The new code governs the spacing starting with the following ETU.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_sel | input | 1 | 0: base enable every cycle; 1: use the `src_sel` rate |
| src_sel | input | 3 | Log2 of the base enable period when `clk_sel`=1 |
| psc_sel | input | 1 | Prescaler ratio: 0 gives 31, 1 gives 32 |
| div_wr_en | input | 1 | Write strobe for the divider code |
| div_wr_data | input | 8 | Divider code to write |
| etu_tick | output | 1 | One-cycle ETU strobe |

## Verification
Some properties are checked on every cycle by assertions:
- the ETU strobe lasts only one cycle and always follows a prescaler terminal count;
- the divider count stays below the active ratio;
- the active ratio is never zero;
- the active ratio changes only at a terminal count;
- the prescaler count stays below its limit.

The actual spacing between strobes can only be shown by the bench's scenarios. Those cover each divider code class, both prescaler ratios and several clock-source rates. The bench scenarios also show that a mid-ETU write leaves the running period intact and takes effect in the period after it.

// File: rtl/etu_pkg.sv
package etu_pkg;
  localparam int unsigned PSC_SHORT = 31;
  localparam int unsigned PSC_LONG  = 32;

  // divider code to effective ratio: 0 and 1 both mean one
  function automatic int unsigned ratio_of(int unsigned code);
    return (code < 2) ? 1 : code;
  endfunction

  // prescaler select to division limit
  function automatic int unsigned psc_limit(logic sel);
    return sel ? PSC_LONG : PSC_SHORT;
  endfunction
endpackage

// File: rtl/etu_src_sel.sv
module etu_src_sel #(
  parameter int SRC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_sel,
  input  logic [SRC_W-1:0] src_sel,
  output logic             src_en
);
  localparam int FREE_W = (2 ** SRC_W) - 1;

  logic [FREE_W-1:0] free_cnt;
  logic [FREE_W-1:0] mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) free_cnt <= '0;
    else        free_cnt <= free_cnt + 1'b1;
  end

  always_comb begin
    mask = '0;
    for (int i = 0; i < FREE_W; i++) begin
      if (i < int'(src_sel)) mask[i] = 1'b1;
    end
  end

  assign src_en = !clk_sel || ((free_cnt & mask) == mask);
endmodule

// File: rtl/etu_prescaler.sv
module etu_prescaler (
  input  logic clk,
  input  logic rst_n,
  input  logic src_en,
  input  logic psc_sel,
  output logic pre_tick
);
  localparam int PW = $clog2(etu_pkg::PSC_LONG + 1);

  logic [PW-1:0] p_cnt;
  logic [PW-1:0] last;

  assign last     = PW'(etu_pkg::psc_limit(psc_sel) - 1);
  assign pre_tick = src_en && (p_cnt >= last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        p_cnt <= '0;
    else if (pre_tick) p_cnt <= '0;
    else if (src_en)   p_cnt <= p_cnt + 1'b1;
  end

  AST_PSC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    p_cnt < PW'(etu_pkg::PSC_LONG)); // R5
endmodule

// File: rtl/etu_divider.sv
module etu_divider #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [DIV_W-1:0] code,
  output logic             div_term,
  output logic             tick_q
);
  logic [DIV_W-1:0] d_cnt;
  logic [DIV_W-1:0] act;

  assign div_term = step && (d_cnt >= act - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_cnt  <= '0;
      act    <= DIV_W'(1);
      tick_q <= 1'b0;
    end else begin
      tick_q <= div_term;
      if (div_term) begin
        d_cnt <= '0;
        act   <= DIV_W'(etu_pkg::ratio_of(int'(code)));
      end else if (step) begin
        d_cnt <= d_cnt + 1'b1;
      end
    end
  end

  AST_DCNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    d_cnt < act); // R2
  AST_ACT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    act != '0); // R3
  AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !div_term |=> $stable(act)); // R8
endmodule

// File: rtl/etu_timer.sv
module etu_timer #(
  parameter int DIV_W = 8,
  parameter int SRC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_sel,
  input  logic [SRC_W-1:0] src_sel,
  input  logic             psc_sel,
  input  logic             div_wr_en,
  input  logic [DIV_W-1:0] div_wr_data,
  output logic             etu_tick
);
  logic [DIV_W-1:0] div_code;
  logic             src_en;
  logic             pre_tick;
  logic             div_term;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         div_code <= '0;
    else if (div_wr_en) div_code <= div_wr_data;
  end

  etu_src_sel #(.SRC_W(SRC_W)) u_src (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .src_sel(src_sel), .src_en(src_en)
  );

  etu_prescaler u_psc (
    .clk(clk), .rst_n(rst_n), .src_en(src_en), .psc_sel(psc_sel), .pre_tick(pre_tick)
  );

  etu_divider #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .step(pre_tick), .code(div_code),
    .div_term(div_term), .tick_q(etu_tick)
  );

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    etu_tick |=> !etu_tick); // R7
  AST_TICK_FROM_PSC: assert property (@(posedge clk) disable iff (!rst_n)
    etu_tick |-> $past(pre_tick)); // R2
endmodule

// File: tb/sim_etu_timer.sv
module sim_etu_timer;
  localparam int CLK_PERIOD = 10;
  localparam int WAIT_MAX   = 40000;
  localparam int NV         = 11;
  // {clk_sel, src_sel, psc_sel, div code, expected gap in cycles}
  localparam logic [32:0] VEC [NV] = '{
    {1'b0, 3'd0, 1'b0, 8'd0,   20'd31},
    {1'b0, 3'd0, 1'b1, 8'd0,   20'd32},
    {1'b0, 3'd0, 1'b0, 8'd1,   20'd31},
    {1'b0, 3'd0, 1'b1, 8'd1,   20'd32},
    {1'b0, 3'd0, 1'b0, 8'd2,   20'd62},
    {1'b0, 3'd0, 1'b1, 8'd2,   20'd64},
    {1'b0, 3'd0, 1'b0, 8'd255, 20'd7905},
    {1'b0, 3'd0, 1'b1, 8'd255, 20'd8160},
    {1'b1, 3'd2, 1'b0, 8'd3,   20'd372},
    {1'b1, 3'd0, 1'b1, 8'd5,   20'd160},
    {1'b1, 3'd3, 1'b1, 8'd2,   20'd512}
  };

  logic       clk = 0;
  logic       rst_n = 0;
  logic       clk_sel = 0;
  logic [2:0] src_sel = 0;
  logic       psc_sel = 0;
  logic       div_wr_en = 0;
  logic [7:0] div_wr_data = 0;
  logic       etu_tick;
  int total = 0;
  int bad = 0;
  int cyc = 0;

  etu_timer u0 (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .src_sel(src_sel),
    .psc_sel(psc_sel), .div_wr_en(div_wr_en), .div_wr_data(div_wr_data),
    .etu_tick(etu_tick)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // waits for a tick sampled at a falling edge; returns its cycle, -1 on timeout
  task automatic next_tick(output int at);
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!etu_tick && n < WAIT_MAX);
    at = etu_tick ? cyc : -1;
    if (at < 0) check("watchdog", 0, 1);
  endtask

  // the cycle after a tick must be low (R7)
  task automatic tick_then_low(output int at);
    next_tick(at);
    @(negedge clk);
    check("R7 width", int'(etu_tick), 0);
  endtask

  task automatic write_div(input logic [7:0] v);
    div_wr_data = v;
    div_wr_en = 1;
    @(negedge clk);
    div_wr_en = 0;
  endtask

  initial begin
    int t0, t1, t2;
    int exp_gap;
    repeat (3) @(negedge clk);
    check("R1 tick low in reset", int'(etu_tick), 0);
    rst_n = 1;
    // R1: default code 00h gives divide-by-one behind the /31 prescaler
    next_tick(t0);
    next_tick(t1);
    check("R1 reset divider spacing", t1 - t0, 31);

    for (int i = 0; i < NV; i++) begin
      clk_sel = VEC[i][32];
      src_sel = VEC[i][31:29];
      psc_sel = VEC[i][28];
      write_div(VEC[i][27:20]);
      next_tick(t0);
      next_tick(t0);
      tick_then_low(t1);
      next_tick(t2);
      exp_gap = int'(VEC[i][19:0]);
      // restated: code<2 -> 1 ; times prescaler ; times source period
      if (exp_gap != ((VEC[i][27:20] < 2) ? 1 : int'(VEC[i][27:20])) *
                     (VEC[i][28] ? 32 : 31) * (VEC[i][32] ? (1 << VEC[i][31:29]) : 1))
        check("table consistency", 0, 1);
      if (VEC[i][27:20] < 2)       check("R3 divide-by-one gap", t2 - t1, exp_gap);
      else if (VEC[i][27:20] == 255) check("R4 max ratio gap", t2 - t1, exp_gap);
      else if (VEC[i][32])        check("R6 source rate gap", t2 - t1, exp_gap);
      else                        check("R2 R5 ratio gap", t2 - t1, exp_gap);
    end

    // R8: mid-ETU write keeps the running ETU, applies to the next one
    clk_sel = 0; src_sel = 0; psc_sel = 0;
    write_div(8'd4);
    next_tick(t0);
    next_tick(t0);
    write_div(8'd10);
    next_tick(t1);
    next_tick(t2);
    check("R8 running ETU kept", t1 - t0, 124);
    check("R8 new code applied", t2 - t1, 310);

    // R5: prescaler /32 with code 3
    psc_sel = 1;
    write_div(8'd3);
    next_tick(t0);
    next_tick(t0);
    next_tick(t1);
    check("R5 psc 32 gap", t1 - t0, 96);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    check("watchdog global", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule